// File: doc/BRIEF.md
# Self-Test Schedule Supervisor

This block drives a precomputed self-test schedule across a set of self-testing units. A schedule table is written before the run. Each row names a unit, a test length counted in base slots, and the earliest slot at which that test may begin. After a `go` pulse, the supervisor walks the rows in index order. For each test it sends the unit an initialize pulse and then a start pulse. It then counts the test length down and raises a result request for that unit. When the unit answers, or when it stays silent for too long, the supervisor records pass or fail.

Tests on different units overlap freely. A short test that ends frees its unit for the next queued row while longer tests keep running. The supervisor never waits for the slowest test of a group. A started test is never cut short. A unit that still owes a result is never started again. When every row has been issued and every unit has returned a result, the block raises `done` next to a vector of per-unit fail bits.

Top module: `bist_sched_supervisor`

## Requirements
- R1: After reset, every initialize, start and request output is low, `busy` and `done` are low and `fail_vec` is zero.
- R2: Rows are issued one per cycle at most, in index order. A row is not issued before the slot counter reaches its start slot. The slot counter is 0 in the first cycle after `go` is accepted and advances every SLOT_CYCLES cycles. The unit's initialize output is high in the cycle after the row is issued.
- R3: Each test begins with a one-cycle initialize pulse on its unit, followed in the very next cycle by a one-cycle start pulse.
- R4: The unit's result request rises len*SLOT_CYCLES+1 cycles after its start pulse. A length of 0 counts as one slot.
- R5: A row whose unit still has an unanswered test waits. Its initialize pulse comes one cycle after that unit's request falls.
- R6: Tests on different units run concurrently. A row with a later start slot begins while an earlier, longer test is still running.
- R7: The request stays high until the unit's `unit_rvalid` is seen and falls one cycle after. `unit_pass`=0 with it sets that unit's `fail_vec` bit. `unit_pass`=1 leaves the bit unchanged.
- R8: With `resp_timeout`=T, a request left unanswered stays high for T+1 cycles, then falls and sets the unit's fail bit. A valid result in the last of those cycles is still accepted.
- R9: `done` rises, and `busy` falls, one cycle after the last request falls. With `run_entries`=0, `done` rises one cycle after `go` is accepted.
- R10: While `busy` is high, `go` and table writes are ignored. A `unit_rvalid` on a unit that is not requesting is ignored.
- R11: Accepting `go` clears `done` and `fail_vec` in the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Schedule table write strobe |
| cfg_idx | input | 3 | Table row to write |
| cfg_unit | input | 3 | Unit index of the row |
| cfg_len | input | 6 | Test length in slots |
| cfg_slot | input | 8 | Earliest start slot of the row |
| run_entries | input | 4 | Number of rows to run, sampled at go |
| resp_timeout | input | 8 | Result wait limit in cycles, sampled at go |
| go | input | 1 | Start the schedule |
| unit_init | output | 8 | Per-unit initialize pulse |
| unit_start | output | 8 | Per-unit start pulse |
| unit_req | output | 8 | Per-unit result request |
| unit_rvalid | input | 8 | Per-unit result valid |
| unit_pass | input | 8 | Per-unit result, 1 = pass |
| busy | output | 1 | Schedule running |
| done | output | 1 | All rows issued and answered |
| fail_vec | output | 8 | Per-unit fail flags |

## Verification
Each result has a fixed latency, measured in clock edges from the edge that accepts `go`:
- A row's initialize pulse appears one edge after the row is issued.
- The start pulse follows one edge after that.
- The request follows len*SLOT_CYCLES+1 edges after the start pulse.
- The request falls one edge after the edge that samples a valid result.
- `done` follows one edge after the last request falls.

The bench keeps its own edge counter and samples every output at the falling edge. It records the edge at which each pulse rises or falls. It compares those numbers with values worked out from the row lengths, start slots, response delays and the timeout. The model responder answers at the falling edge, so each answer is sampled at the following rising edge, exactly as the expected numbers assume.

// File: rtl/bist_sup_pkg.sv
package bist_sup_pkg;

  typedef enum logic [2:0] {
    U_IDLE  = 3'd0,
    U_INIT  = 3'd1,
    U_START = 3'd2,
    U_RUN   = 3'd3,
    U_REQ   = 3'd4
  } unit_st_e;

  // A zero-length test still occupies one slot.
  function automatic int unsigned eff_slots(input int unsigned len);
    return (len == 0) ? 1 : len;
  endfunction

  // Number of cycles a test spends in the running state.
  function automatic int unsigned run_cycles(input int unsigned len,
                                             input int unsigned slot_cycles);
    return eff_slots(len) * slot_cycles;
  endfunction

endpackage

// File: rtl/sup_sched_store.sv
module sup_sched_store #(
  parameter int MAX_ENTRIES = 8,
  parameter int UNIT_W      = 3,
  parameter int LEN_W       = 6,
  parameter int SLOT_W      = 8,
  localparam int IDX_W      = $clog2(MAX_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [UNIT_W-1:0] wunit,
  input  logic [LEN_W-1:0]  wlen,
  input  logic [SLOT_W-1:0] wslot,
  input  logic [IDX_W-1:0]  raddr,
  output logic [UNIT_W-1:0] runit,
  output logic [LEN_W-1:0]  rlen,
  output logic [SLOT_W-1:0] rslot
);

  logic [UNIT_W-1:0] unit_a [MAX_ENTRIES];
  logic [LEN_W-1:0]  len_a  [MAX_ENTRIES];
  logic [SLOT_W-1:0] slot_a [MAX_ENTRIES];

  for (genvar e = 0; e < MAX_ENTRIES; e++) begin : g_row
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        unit_a[e] <= '0;
        len_a[e]  <= '0;
        slot_a[e] <= '0;
      end else if (we && (waddr == IDX_W'(e))) begin
        unit_a[e] <= wunit;
        len_a[e]  <= wlen;
        slot_a[e] <= wslot;
      end
    end
  end

  assign runit = unit_a[raddr];
  assign rlen  = len_a[raddr];
  assign rslot = slot_a[raddr];

endmodule

// File: rtl/sup_slot_timer.sv
module sup_slot_timer #(
  parameter int SLOT_CYCLES = 4,
  parameter int SLOT_W      = 8,
  localparam int PH_W       = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              run,
  output logic [SLOT_W-1:0] slot_now
);

  logic [PH_W-1:0] phase;
  logic            slot_wrap;
  logic            slot_sat;

  assign slot_wrap = (phase == PH_W'(SLOT_CYCLES - 1));
  assign slot_sat  = (slot_now == {SLOT_W{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= '0;
      slot_now <= '0;
    end else if (clear) begin
      phase    <= '0;
      slot_now <= '0;
    end else if (run) begin
      if (slot_wrap) begin
        phase <= '0;
        if (!slot_sat) slot_now <= slot_now + 1'b1;
      end else begin
        phase <= phase + 1'b1;
      end
    end
  end

  AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    run && !clear |=> (slot_now == $past(slot_now)) ||
                      (slot_now == $past(slot_now) + 1'b1)); // R2

endmodule

// File: rtl/sup_unit_ctrl.sv
module sup_unit_ctrl
  import bist_sup_pkg::*;
#(
  parameter int LEN_W       = 6,
  parameter int SLOT_CYCLES = 4,
  parameter int TMO_W       = 8,
  localparam int CNT_W      = LEN_W + $clog2(SLOT_CYCLES + 1) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic [LEN_W-1:0] len,
  input  logic [TMO_W-1:0] tmo_limit,
  input  logic             rvalid,
  input  logic             rpass,
  output logic             idle,
  output logic             init_o,
  output logic             start_o,
  output logic             req_o,
  output logic             result_ev,
  output logic             result_fail
);

  unit_st_e         st;
  logic [LEN_W-1:0] len_q;
  logic [CNT_W-1:0] cnt;
  logic [TMO_W-1:0] tcnt;
  logic             tmo_hit;

  assign idle    = (st == U_IDLE);
  assign init_o  = (st == U_INIT);
  assign start_o = (st == U_START);
  assign req_o   = (st == U_REQ);
  assign tmo_hit = req_o && !rvalid && (tcnt == tmo_limit);

  assign result_ev   = req_o && (rvalid || tmo_hit);
  assign result_fail = rvalid ? !rpass : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= U_IDLE;
      len_q <= '0;
      cnt   <= '0;
      tcnt  <= '0;
    end else begin
      unique case (st)
        U_IDLE: if (launch) begin
          len_q <= len;
          st    <= U_INIT;
        end
        U_INIT:  st <= U_START;
        U_START: begin
          cnt <= CNT_W'(run_cycles(32'(len_q), SLOT_CYCLES));
          st  <= U_RUN;
        end
        U_RUN: begin
          if (cnt <= CNT_W'(1)) begin
            tcnt <= '0;
            st   <= U_REQ;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        U_REQ: begin
          if (result_ev) st <= U_IDLE;
          else           tcnt <= tcnt + 1'b1;
        end
        default: st <= U_IDLE;
      endcase
    end
  end

  AST_START_AFTER_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    init_o |=> start_o && !init_o); // R3
  AST_CMD_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({init_o, start_o, req_o})); // R3
  AST_NO_LAUNCH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> idle); // R5
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    req_o && !rvalid && (tcnt != tmo_limit) |=> req_o); // R7
  AST_REQ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    result_ev |=> !req_o); // R7
  AST_TMO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> tcnt <= tmo_limit); // R8

endmodule

// File: rtl/bist_sched_supervisor.sv
module bist_sched_supervisor
  import bist_sup_pkg::*;
#(
  parameter int NUM_UNITS   = 8,
  parameter int MAX_ENTRIES = 8,
  parameter int LEN_W       = 6,
  parameter int SLOT_W      = 8,
  parameter int SLOT_CYCLES = 4,
  parameter int TMO_W       = 8,
  localparam int UNIT_W     = $clog2(NUM_UNITS),
  localparam int IDX_W      = $clog2(MAX_ENTRIES),
  localparam int PTR_W      = IDX_W + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [IDX_W-1:0]     cfg_idx,
  input  logic [UNIT_W-1:0]    cfg_unit,
  input  logic [LEN_W-1:0]     cfg_len,
  input  logic [SLOT_W-1:0]    cfg_slot,
  input  logic [PTR_W-1:0]     run_entries,
  input  logic [TMO_W-1:0]     resp_timeout,
  input  logic                 go,
  output logic [NUM_UNITS-1:0] unit_init,
  output logic [NUM_UNITS-1:0] unit_start,
  output logic [NUM_UNITS-1:0] unit_req,
  input  logic [NUM_UNITS-1:0] unit_rvalid,
  input  logic [NUM_UNITS-1:0] unit_pass,
  output logic                 busy,
  output logic                 done,
  output logic [NUM_UNITS-1:0] fail_vec
);

  logic                 running;
  logic [PTR_W-1:0]     ptr;
  logic [PTR_W-1:0]     count_q;
  logic [TMO_W-1:0]     tmo_q;
  logic [SLOT_W-1:0]    slot_now;
  logic [UNIT_W-1:0]    cur_unit;
  logic [LEN_W-1:0]     cur_len;
  logic [SLOT_W-1:0]    cur_slot;
  logic                 go_acc;
  logic                 rows_left;
  logic                 slot_ready;
  logic                 cur_idle;
  logic                 launch_any;
  logic                 all_idle;
  logic                 sched_finish;
  logic [NUM_UNITS-1:0] unit_idle;
  logic [NUM_UNITS-1:0] unit_launch;
  logic [NUM_UNITS-1:0] res_ev;
  logic [NUM_UNITS-1:0] res_fail;
  logic [PTR_W-1:0]     count_clamped;

  assign go_acc        = go && !running;
  assign count_clamped = (run_entries > PTR_W'(MAX_ENTRIES)) ?
                         PTR_W'(MAX_ENTRIES) : run_entries;

  sup_sched_store #(
    .MAX_ENTRIES(MAX_ENTRIES), .UNIT_W(UNIT_W), .LEN_W(LEN_W), .SLOT_W(SLOT_W)
  ) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we && !running),
    .waddr (cfg_idx),
    .wunit (cfg_unit),
    .wlen  (cfg_len),
    .wslot (cfg_slot),
    .raddr (ptr[IDX_W-1:0]),
    .runit (cur_unit),
    .rlen  (cur_len),
    .rslot (cur_slot)
  );

  sup_slot_timer #(.SLOT_CYCLES(SLOT_CYCLES), .SLOT_W(SLOT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (go_acc),
    .run      (running),
    .slot_now (slot_now)
  );

  always_comb begin
    cur_idle = 1'b0;
    for (int u = 0; u < NUM_UNITS; u++)
      if (cur_unit == UNIT_W'(u)) cur_idle = unit_idle[u];
  end

  assign rows_left    = (ptr < count_q);
  assign slot_ready   = (cur_slot <= slot_now);
  assign launch_any   = running && rows_left && slot_ready && cur_idle;
  assign all_idle     = &unit_idle;
  assign sched_finish = running && !rows_left && all_idle;

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    assign unit_launch[u] = launch_any && (cur_unit == UNIT_W'(u));

    sup_unit_ctrl #(
      .LEN_W(LEN_W), .SLOT_CYCLES(SLOT_CYCLES), .TMO_W(TMO_W)
    ) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .launch      (unit_launch[u]),
      .len         (cur_len),
      .tmo_limit   (tmo_q),
      .rvalid      (unit_rvalid[u]),
      .rpass       (unit_pass[u]),
      .idle        (unit_idle[u]),
      .init_o      (unit_init[u]),
      .start_o     (unit_start[u]),
      .req_o       (unit_req[u]),
      .result_ev   (res_ev[u]),
      .result_fail (res_fail[u])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running  <= 1'b0;
      ptr      <= '0;
      count_q  <= '0;
      tmo_q    <= '0;
      done     <= 1'b0;
      fail_vec <= '0;
    end else if (go_acc) begin
      running  <= 1'b1;
      ptr      <= '0;
      count_q  <= count_clamped;
      tmo_q    <= resp_timeout;
      done     <= 1'b0;
      fail_vec <= '0;
    end else if (running) begin
      if (launch_any) ptr <= ptr + 1'b1;
      fail_vec <= fail_vec | (res_ev & res_fail);
      if (sched_finish) begin
        running <= 1'b0;
        done    <= 1'b1;
      end
    end
  end

  assign busy = running;

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (unit_init == '0) && (unit_start == '0) && (unit_req == '0)); // R9
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy)); // R9
  AST_PTR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= count_q); // R2
  AST_ONE_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(unit_init)); // R2
  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> ((fail_vec & $past(fail_vec)) == $past(fail_vec))); // R7

endmodule

// File: tb/bist_sched_supervisor_bench.sv
module bist_sched_supervisor_bench;

  localparam int CLK_PERIOD = 10;
  localparam int SC         = 4;
  localparam int NU         = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_idx = '0;
  logic [2:0] cfg_unit = '0;
  logic [5:0] cfg_len = '0;
  logic [7:0] cfg_slot = '0;
  logic [3:0] run_entries = '0;
  logic [7:0] resp_timeout = 8'd20;
  logic       go = 1'b0;
  logic [NU-1:0] unit_init, unit_start, unit_req;
  logic [NU-1:0] rv_auto = '0, rv_man = '0, rp_auto = '0;
  logic [NU-1:0] unit_rvalid, unit_pass;
  logic busy, done;
  logic [NU-1:0] fail_vec;

  assign unit_rvalid = rv_auto | rv_man;
  assign unit_pass   = rp_auto;

  bist_sched_supervisor #(.SLOT_CYCLES(SC)) u_bist_sched_supervisor (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_unit(cfg_unit), .cfg_len(cfg_len), .cfg_slot(cfg_slot),
    .run_entries(run_entries), .resp_timeout(resp_timeout), .go(go),
    .unit_init(unit_init), .unit_start(unit_start), .unit_req(unit_req),
    .unit_rvalid(unit_rvalid), .unit_pass(unit_pass), .busy(busy),
    .done(done), .fail_vec(fail_vec));

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;
  int go_cyc = 0;

  int init_cnt[NU], init_last[NU], start_last[NU], req_rise[NU], req_fall[NU];
  int done_cyc = -1;
  logic [NU-1:0] p_init = '0, p_start = '0, p_req = '0;
  logic p_done = 1'b0;

  bit resp_en[NU];
  int resp_delay[NU];
  bit resp_pass[NU];
  int waited[NU];

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Event log, sampled at the falling edge.
  initial begin
    forever begin
      @(negedge clk);
      for (int u = 0; u < NU; u++) begin
        if (unit_init[u] && !p_init[u]) begin init_cnt[u]++; init_last[u] = cyc; end
        if (unit_start[u] && !p_start[u]) start_last[u] = cyc;
        if (unit_req[u] && !p_req[u]) req_rise[u] = cyc;
        if (!unit_req[u] && p_req[u]) req_fall[u] = cyc;
      end
      if (done && !p_done) done_cyc = cyc;
      p_init = unit_init; p_start = unit_start; p_req = unit_req; p_done = done;
    end
  end

  // Model units: answer after a set number of request cycles.
  initial begin
    forever begin
      @(negedge clk);
      for (int u = 0; u < NU; u++) begin
        if (unit_req[u]) begin
          if (resp_en[u] && waited[u] == resp_delay[u]) begin
            rv_auto[u] = 1'b1; rp_auto[u] = resp_pass[u];
          end else begin
            rv_auto[u] = 1'b0;
          end
          waited[u]++;
        end else begin
          rv_auto[u] = 1'b0; waited[u] = 0;
        end
      end
    end
  end

  task automatic clear_log();
    for (int u = 0; u < NU; u++) begin
      init_cnt[u] = 0; init_last[u] = -1; start_last[u] = -1;
      req_rise[u] = -1; req_fall[u] = -1;
      resp_en[u] = 1'b1; resp_delay[u] = 0; resp_pass[u] = 1'b1;
    end
    done_cyc = -1;
  endtask

  task automatic load_row(input int idx, input int unit, input int len, input int slot);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_unit = 3'(unit);
    cfg_len = 6'(len); cfg_slot = 8'(slot);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run_sched(input int n, input int tmo);
    @(negedge clk);
    go = 1'b1; run_entries = 4'(n); resp_timeout = 8'(tmo);
    @(negedge clk);
    go = 1'b0;
    go_cyc = cyc;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 500) begin @(negedge clk); n++; end
  endtask

  task automatic t_reset();
    chk("R1 init", int'(unit_init), 0);
    chk("R1 start", int'(unit_start), 0);
    chk("R1 req", int'(unit_req), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 fail", int'(fail_vec), 0);
  endtask

  task automatic t_single();
    clear_log();
    load_row(0, 2, 3, 2);
    run_sched(1, 20);
    chk("R10 busy during run", int'(busy), 1);
    wait_done();
    chk("R2 init at slot 2", init_last[2], go_cyc + 2*SC + 1);
    chk("R3 start follows init", start_last[2] - init_last[2], 1);
    chk("R4 req after start", req_rise[2] - start_last[2], 3*SC + 1);
    chk("R7 req falls", req_fall[2], req_rise[2] + 1);
    chk("R9 done edge", done_cyc, req_fall[2] + 1);
    chk("R9 busy low", int'(busy), 0);
    chk("R7 pass keeps bit", int'(fail_vec), 0);
  endtask

  task automatic t_overlap();
    int g;
    clear_log();
    load_row(0, 0, 1, 0);
    load_row(1, 1, 4, 0);
    load_row(2, 3, 2, 1);
    resp_pass[0] = 1'b0;
    resp_delay[1] = 2;
    resp_delay[3] = 1;
    run_sched(3, 20);
    g = go_cyc;
    repeat (6) @(negedge clk);
    go = 1'b1; run_entries = 4'd0;
    cfg_we = 1'b1; cfg_idx = 3'd0; cfg_unit = 3'd7; cfg_len = 6'd1; cfg_slot = 8'd0;
    rv_man[6] = 1'b1;
    @(negedge clk);
    go = 1'b0; cfg_we = 1'b0; rv_man[6] = 1'b0;
    wait_done();
    chk("R2 unit0 init", init_last[0], g + 1);
    chk("R2 unit1 init next cycle", init_last[1], g + 2);
    chk("R2 unit3 init at slot 1", init_last[3], g + SC + 1);
    chk("R6 unit3 starts before unit1 ends", int'(init_last[3] < req_rise[1]), 1);
    chk("R4 long test length", req_rise[1] - start_last[1], 4*SC + 1);
    chk("R7 delayed answer", req_fall[1], req_rise[1] + 3);
    chk("R10 go ignored while busy", done_cyc, g + 3 + 4*SC + 1 + 3 + 1);
    chk("R10 no extra init", init_cnt[0] + init_cnt[1] + init_cnt[3], 3);
    chk("R7 fail bits (R10 spurious unit6 ignored)", int'(fail_vec), 8'h01);
  endtask

  task automatic t_load_ignored();
    clear_log();
    run_sched(1, 20);
    wait_done();
    chk("R10 row 0 kept unit0", init_cnt[0], 1);
    chk("R10 row 0 not unit7", init_cnt[7], 0);
  endtask

  task automatic t_same_unit();
    int g;
    clear_log();
    load_row(0, 4, 1, 0);
    load_row(1, 4, 2, 0);
    run_sched(2, 20);
    g = go_cyc;
    wait_done();
    chk("R5 two tests on unit4", init_cnt[4], 2);
    chk("R5 second init after first answer", init_last[4], g + 9);
    chk("R4 second length", req_rise[4] - start_last[4], 2*SC + 1);
    chk("R9 done after second", done_cyc, g + 2*SC + 13);
  endtask

  task automatic t_timeout();
    int g;
    clear_log();
    load_row(0, 5, 1, 0);
    load_row(1, 2, 1, 0);
    resp_en[5] = 1'b0;
    resp_delay[2] = 5;
    run_sched(2, 5);
    g = go_cyc;
    wait_done();
    chk("R8 timeout width", req_fall[5] - req_rise[5], 6);
    chk("R8 last-cycle answer width", req_fall[2] - req_rise[2], 6);
    chk("R8 timeout fail bit only", int'(fail_vec), 8'h20);
    chk("R9 done after timeout", done_cyc, g + SC + 11);
  endtask

  task automatic t_clear_zero();
    clear_log();
    load_row(0, 6, 0, 0);
    run_sched(1, 20);
    chk("R11 fail cleared", int'(fail_vec), 0);
    chk("R11 done cleared", int'(done), 0);
    wait_done();
    chk("R4 zero length is one slot", req_rise[6] - start_last[6], SC + 1);
    chk("R7 clean run", int'(fail_vec), 0);
  endtask

  task automatic t_empty();
    clear_log();
    run_sched(0, 20);
    wait_done();
    chk("R9 empty schedule done", done_cyc, go_cyc + 1);
    chk("R9 no commands", init_cnt[0] + init_cnt[1] + init_cnt[2] + init_cnt[6], 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    clear_log();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_single();
    t_overlap();
    t_load_ignored();
    t_same_unit();
    t_timeout();
    t_clear_zero();
    t_empty();
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule